// File: doc/BRIEF.md
# Multiplexed External Bus Strobe Sequencer

This block produces the external-memory timing for an 8-bit controller whose low address byte and data share one port. It divides the oscillator clock by two to obtain phases. Two phases make one state, and a fixed number of states make one machine cycle. From that cadence it drives four strobes: an address-latch pulse, an active-low program-store read strobe, and active-low data read and write strobes. It also drives the low multiplexed port and the high address port.

In normal operation each machine cycle carries two code fetches. The core presents the fetch address on `fetch_addr`. When the core raises a data request, the sequencer accepts it at the end of a machine cycle and runs a two-cycle data access. The first cycle fetches once and then sends the data address. The second cycle performs the transfer and then fetches again. During the access one address-latch pulse and two program-store pulses are left out. For a narrow (8-bit address) access the high port shows the port register rather than the upper address byte.

Top module: `bus_strobe_seq`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `p0_oe` is 0 and `data_ack` is 0.
- R2: Each state lasts two oscillator clocks and a machine cycle is 2*STATES clocks. `ale` is high for exactly two clocks, starting at state 0 and at state STATES/2, so with the default of six states it rises once every six clocks.
- R3: With `ext_code`=1 in a cycle with no data access, `psen_n` goes low twice: in states 1..STATES/2-1 and in states STATES/2+1..STATES-1. It is never low while `ale` is high.
- R4: With `ext_code`=0, `psen_n` stays high, `ale` keeps its cadence, the fetch address is not driven on the low port, and `p2_out` shows `p2_reg`.
- R5: `data_req` is accepted only in the last clock of a machine cycle, signalled by a one-clock `data_ack`. It is not accepted in the last clock of the first cycle of a data access.
- R6: A data access spans two machine cycles. Compared with two fetch cycles, it leaves out the address-latch pulse at state 0 of the second cycle and the program-store pulses of the second half of the first cycle and the first half of the second cycle. That gives three `ale` pulses and two `psen_n` pulses over the pair.
- R7: During the address-latch pulse at state STATES/2 of the first access cycle, `p0_oe`=1 and `p0_out` is the low byte of `data_addr` as latched at acceptance.
- R8: From state STATES/2 of the first access cycle through state STATES/2-1 of the second, `p2_out` is the upper byte of the latched address when `data_wide`=1. It is the live `p2_reg` when `data_wide`=0.
- R9: For a write (`data_write`=1), `wr_n` is low for states 0..STATES/2-1 of the second cycle, `p0_oe`=1 and `p0_out` is the latched write data. `rd_n` stays high.
- R10: For a read, `rd_n` is low over the same window with `p0_oe`=0. `p0_in` is captured into `rd_data` on the last clock of the window, and `rd_valid` pulses for one clock right after it.
- R11: With `ext_code`=1, a fetch address-latch pulse drives `p0_out` with the low byte and `p2_out` with the high byte of `fetch_addr`, with `p0_oe`=1.
- R12: A request held high through an access is accepted at the end of its second cycle, and the next cycle is again the first cycle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_code | input | 1 | 1 = code is fetched from external memory |
| fetch_addr | input | 16 | Code address of the current fetch |
| p2_reg | input | 8 | Contents of the high-port register |
| data_req | input | 1 | Data access request, held until acknowledged |
| data_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| data_write | input | 1 | 1 = write, 0 = read |
| data_addr | input | 16 | Data address |
| data_wdata | input | 8 | Write data |
| p0_in | input | 8 | Value read back from the low port pins |
| data_ack | output | 1 | Request accepted this clock |
| ale | output | 1 | Address-latch pulse, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low port: address low byte or write data |
| p0_oe | output | 1 | Low port output enable |
| p2_out | output | 8 | High port value |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-clock pulse when rd_data is updated |

## Verification
The bench builds the block with its defaults: an 8-bit port, a 16-bit address and six states per machine cycle. Under these values a machine cycle is twelve clocks, so every edge of every strobe in a cycle can be recorded and counted. The bench compares rising `ale` edges and falling `psen_n`, `rd_n` and `wr_n` edges against their expected count and clock slot. It does this for external fetch, internal fetch, wide write, narrow read, wide read and back-to-back accesses. With six states the two halves of a cycle are three states long, so the separate program-store pulse windows, the port-register source for the high byte and the capture on the last transfer clock each appear at a distinct clock.

// File: rtl/bss_pkg.sv
// Shared types for the bus strobe sequencer.
// Assumes: a data access always occupies exactly two machine cycles.
package bss_pkg;

    // Kind of the current machine cycle.
    typedef enum logic [1:0] {
        MC_FETCH = 2'd0,   // two code fetches
        MC_DADDR = 2'd1,   // one fetch, then data address out
        MC_DXFER = 2'd2    // data transfer, then one fetch
    } mc_mode_e;

    // Strobe bundle produced by the decoder.
    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
    } strobe_t;

endpackage

// File: rtl/bss_phase_gen.sv
// Divides the oscillator by two into phases and counts states.
// Assumes STATES >= 4 and even; state 0 phase 0 is the first clock of a cycle.
module bss_phase_gen #(
    parameter int STATES = 6,
    localparam int SW = $clog2(STATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] state,
    output logic          phase,
    output logic          last_tick
);
    localparam logic [SW-1:0] LAST_S = SW'(STATES - 1);

    // Divide-by-two phase toggle and state advance on the second phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            state <= '0;
        end else begin
            phase <= ~phase;
            if (phase) begin
                state <= (state == LAST_S) ? '0 : state + SW'(1);
            end
        end
    end

    // Marks the final clock of the machine cycle.
    always_comb begin
        last_tick = rst_n && phase && (state == LAST_S);
    end
endmodule

// File: rtl/bss_cycle_ctrl.sv
// Chooses the kind of each machine cycle and latches accepted data requests.
// Assumes the requester holds data_req and its fields until data_ack.
module bss_cycle_ctrl
    import bss_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          last_tick,
    input  logic          data_req,
    input  logic          data_wide,
    input  logic          data_write,
    input  logic [AW-1:0] data_addr,
    input  logic [DW-1:0] data_wdata,
    output mc_mode_e      mode,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    output logic          acc_wide,
    output logic          acc_write,
    output logic          data_ack
);
    logic accept;

    // Acceptance: cycle boundary, not inside the address cycle of an access.
    always_comb begin
        accept   = rst_n && last_tick && data_req && (mode != MC_DADDR);
        data_ack = accept;
    end

    // Advance the cycle kind at each cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MC_FETCH;
        end else if (last_tick) begin
            if (mode == MC_DADDR) begin
                mode <= MC_DXFER;
            end else begin
                mode <= accept ? MC_DADDR : MC_FETCH;
            end
        end
    end

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr  <= '0;
            acc_wdata <= '0;
            acc_wide  <= 1'b0;
            acc_write <= 1'b0;
        end else if (accept) begin
            acc_addr  <= data_addr;
            acc_wdata <= data_wdata;
            acc_wide  <= data_wide;
            acc_write <= data_write;
        end
    end
endmodule

// File: rtl/bss_strobe_dec.sv
// Decodes state and cycle kind into the four bus strobes.
// Assumes STATES even; the first half of a cycle is states 0..STATES/2-1.
module bss_strobe_dec
    import bss_pkg::*;
#(
    parameter int STATES = 6,
    localparam int SW = $clog2(STATES)
) (
    input  logic          rst_n,
    input  mc_mode_e      mode,
    input  logic [SW-1:0] state,
    input  logic          ext_code,
    input  logic          acc_write,
    output strobe_t       strb
);
    localparam logic [SW-1:0] HALF_S = SW'(STATES / 2);
    localparam logic [SW-1:0] ONE_S  = SW'(1);

    logic ale_lo, ale_hi, ps_lo, ps_hi, xfer;

    // Strobe windows; the data cycles drop selected fetch windows.
    always_comb begin
        ale_lo = (state == '0) && (mode != MC_DXFER);
        ale_hi = (state == HALF_S);
        ps_lo  = (state >= ONE_S) && (state < HALF_S) && (mode != MC_DXFER);
        ps_hi  = (state > HALF_S) && (mode != MC_DADDR);
        xfer   = (mode == MC_DXFER) && (state < HALF_S);

        strb.ale    = rst_n && (ale_lo || ale_hi);
        strb.psen_n = !(rst_n && ext_code && (ps_lo || ps_hi));
        strb.rd_n   = !(rst_n && xfer && !acc_write);
        strb.wr_n   = !(rst_n && xfer && acc_write);
    end
endmodule

// File: rtl/bss_port_mux.sv
// Selects the low and high port values and captures read data.
// Assumes the low port is half the address width.
module bss_port_mux
    import bss_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STATES = 6,
    localparam int AW = 2 * DW,
    localparam int SW = $clog2(STATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mc_mode_e      mode,
    input  logic [SW-1:0] state,
    input  logic          phase,
    input  logic          ale,
    input  logic          ext_code,
    input  logic [AW-1:0] fetch_addr,
    input  logic [DW-1:0] p2_reg,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic          acc_wide,
    input  logic          acc_write,
    input  logic [DW-1:0] p0_in,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    output logic [DW-1:0] p2_out,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam logic [SW-1:0] HALF_S = SW'(STATES / 2);
    localparam logic [SW-1:0] CAP_S  = SW'(STATES / 2 - 1);

    logic data_phase, in_xfer, data_ale, capture;
    logic [DW-1:0] hi_data;

    // Window flags for the data part of an access.
    always_comb begin
        data_ale   = (mode == MC_DADDR) && (state == HALF_S);
        in_xfer    = (mode == MC_DXFER) && (state < HALF_S);
        data_phase = ((mode == MC_DADDR) && (state >= HALF_S)) || in_xfer;
        hi_data    = acc_wide ? acc_addr[AW-1:DW] : p2_reg;
        capture    = rst_n && in_xfer && !acc_write && phase && (state == CAP_S);
    end

    // High port source selection.
    always_comb begin
        if (data_phase) begin
            p2_out = hi_data;
        end else if (ext_code) begin
            p2_out = fetch_addr[AW-1:DW];
        end else begin
            p2_out = p2_reg;
        end
    end

    // Low port: address, write data or released.
    always_comb begin
        p0_oe  = 1'b0;
        p0_out = '0;
        if (!rst_n) begin
            p0_oe = 1'b0;
        end else if (data_ale) begin
            p0_oe  = 1'b1;
            p0_out = acc_addr[DW-1:0];
        end else if (in_xfer) begin
            p0_oe  = acc_write;
            p0_out = acc_write ? acc_wdata : '0;
        end else if (ale && ext_code) begin
            p0_oe  = 1'b1;
            p0_out = fetch_addr[DW-1:0];
        end
    end

    // Capture read data at the last clock of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= p0_in;
            end
        end
    end
endmodule

// File: rtl/bus_strobe_seq.sv
// Top of the multiplexed external bus strobe sequencer.
// Assumes the clock is the oscillator and reset is synchronous, active low.
module bus_strobe_seq
    import bss_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STATES = 6,
    localparam int AW = 2 * DW,
    localparam int SW = $clog2(STATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_code,
    input  logic [AW-1:0] fetch_addr,
    input  logic [DW-1:0] p2_reg,
    input  logic          data_req,
    input  logic          data_wide,
    input  logic          data_write,
    input  logic [AW-1:0] data_addr,
    input  logic [DW-1:0] data_wdata,
    input  logic [DW-1:0] p0_in,
    output logic          data_ack,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    output logic [DW-1:0] p2_out,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [SW-1:0] state;
    logic          phase, last_tick;
    mc_mode_e      mode;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata;
    logic          acc_wide, acc_write;
    strobe_t       strb;

    bss_phase_gen #(.STATES(STATES)) u_phase (
        .clk(clk), .rst_n(rst_n), .state(state), .phase(phase),
        .last_tick(last_tick)
    );

    bss_cycle_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .last_tick(last_tick),
        .data_req(data_req), .data_wide(data_wide), .data_write(data_write),
        .data_addr(data_addr), .data_wdata(data_wdata), .mode(mode),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_wide(acc_wide),
        .acc_write(acc_write), .data_ack(data_ack)
    );

    bss_strobe_dec #(.STATES(STATES)) u_dec (
        .rst_n(rst_n), .mode(mode), .state(state), .ext_code(ext_code),
        .acc_write(acc_write), .strb(strb)
    );

    bss_port_mux #(.DW(DW), .STATES(STATES)) u_mux (
        .clk(clk), .rst_n(rst_n), .mode(mode), .state(state), .phase(phase),
        .ale(strb.ale), .ext_code(ext_code), .fetch_addr(fetch_addr),
        .p2_reg(p2_reg), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_wide(acc_wide), .acc_write(acc_write), .p0_in(p0_in),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Strobe outputs from the decoder bundle.
    always_comb begin
        ale    = strb.ale;
        psen_n = strb.psen_n;
        rd_n   = strb.rd_n;
        wr_n   = strb.wr_n;
    end
endmodule

// File: rtl/bus_strobe_seq_chk.sv
// Protocol checker for bus_strobe_seq, attached by bind.
// Assumes it sees the top-level ports only.
module bus_strobe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_code,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic p0_oe,
    input logic data_ack,
    input logic rd_valid
);
    // R1: all strobes idle while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_idle_in_reset_R1: assert (!ale && psen_n && rd_n && wr_n && !p0_oe && !data_ack)
                else $error("strobe active during reset");
        end
    end

    assert_ale_two_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale);
    assert_ale_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> ##2 !ale);
    assert_no_psen_with_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> psen_n);
    assert_psen_off_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_code |-> psen_n);
    assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_ack |=> !data_ack);
    assert_no_fetch_in_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (psen_n && !ale));
    assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);
    assert_read_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !p0_oe);
    assert_valid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!rd_n));
    assert_fetch_ale_drives_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && ext_code) |-> p0_oe);
endmodule

bind bus_strobe_seq bus_strobe_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ext_code(ext_code), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_oe(p0_oe),
    .data_ack(data_ack), .rd_valid(rd_valid)
);

// File: tb/bus_strobe_seq_tb_top.sv
`timescale 1ns/1ps
module bus_strobe_seq_tb_top;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam int MC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_code = 1'b1;
    logic [AW-1:0] fetch_addr = '0;
    logic [DW-1:0] p2_reg = '0;
    logic          data_req = 1'b0;
    logic          data_wide = 1'b0;
    logic          data_write = 1'b0;
    logic [AW-1:0] data_addr = '0;
    logic [DW-1:0] data_wdata = '0;
    logic [DW-1:0] p0_in = '0;
    logic          data_ack, ale, psen_n, rd_n, wr_n, p0_oe, rd_valid;
    logic [DW-1:0] p0_out, p2_out, rd_data;

    int total = 0;
    int bad   = 0;

    // Per-cycle records.
    logic          s_oe  [MC];
    logic [DW-1:0] s_p0  [MC];
    logic [DW-1:0] s_p2  [MC];
    logic          s_vld [MC];
    logic          s_ack [MC];
    int n_ale_rise, n_ale_hi, n_ps_fall, n_ps_lo, n_rd_fall, n_wr_fall, n_ack, n_vld;
    int ale_pos0, ale_pos1;
    logic prev_ale = 1'b0, prev_ps = 1'b1, prev_rd = 1'b1, prev_wr = 1'b1;

    always #2 clk = ~clk;

    bus_strobe_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ext_code(ext_code), .fetch_addr(fetch_addr),
        .p2_reg(p2_reg), .data_req(data_req), .data_wide(data_wide),
        .data_write(data_write), .data_addr(data_addr), .data_wdata(data_wdata),
        .p0_in(p0_in), .data_ack(data_ack), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
        .p2_out(p2_out), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Records one machine cycle; entered and left at a negedge at state 0.
    task automatic run_cycle();
        n_ale_rise = 0; n_ale_hi = 0; n_ps_fall = 0; n_ps_lo = 0;
        n_rd_fall = 0; n_wr_fall = 0; n_ack = 0; n_vld = 0;
        ale_pos0 = -1; ale_pos1 = -1;
        for (int i = 0; i < MC; i++) begin
            #1;
            if (ale && !prev_ale) begin
                n_ale_rise++;
                if (ale_pos0 < 0) ale_pos0 = i; else ale_pos1 = i;
            end
            if (ale) n_ale_hi++;
            if (!psen_n && prev_ps) n_ps_fall++;
            if (!psen_n) n_ps_lo++;
            if (!rd_n && prev_rd) n_rd_fall++;
            if (!wr_n && prev_wr) n_wr_fall++;
            if (data_ack) n_ack++;
            if (rd_valid) n_vld++;
            s_oe[i] = p0_oe; s_p0[i] = p0_out; s_p2[i] = p2_out;
            s_vld[i] = rd_valid; s_ack[i] = data_ack;
            prev_ale = ale; prev_ps = psen_n; prev_rd = rd_n; prev_wr = wr_n;
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            chk("R1 ale in reset", int'(ale), 0);
            chk("R1 strobes high in reset", int'(psen_n && rd_n && wr_n), 1);
            chk("R1 p0_oe/ack in reset", int'(p0_oe || data_ack), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_fetch_ext();
        ext_code = 1'b1; fetch_addr = 16'hA55A; p2_reg = 8'h11;
        run_cycle();
        chk("R2 ale rises per cycle", n_ale_rise, 2);
        chk("R2 ale high clocks", n_ale_hi, 4);
        chk("R2 first ale slot", ale_pos0, 0);
        chk("R2 second ale slot", ale_pos1, 6);
        chk("R3 psen pulses", n_ps_fall, 2);
        chk("R3 psen low clocks", n_ps_lo, 8);
        chk("R11 p0 fetch low byte", int'(s_p0[0]), 'h5A);
        chk("R11 p0 driven at ale", int'(s_oe[0]), 1);
        chk("R11 p2 fetch high byte", int'(s_p2[0]), 'hA5);
        chk("R5 no ack without request", n_ack, 0);
    endtask

    task automatic test_fetch_int();
        ext_code = 1'b0; p2_reg = 8'h3C;
        run_cycle();
        chk("R4 no psen when internal", n_ps_fall, 0);
        chk("R4 ale keeps cadence", n_ale_rise, 2);
        chk("R4 p2 shows register", int'(s_p2[3]), 'h3C);
        chk("R4 p0 not driven at ale", int'(s_oe[0]), 0);
        ext_code = 1'b1;
    endtask

    // One full access from a fetch cycle with the request raised.
    task automatic test_access(input logic wide, input logic wr, input logic [AW-1:0] addr,
                               input logic [DW-1:0] wd, input logic [DW-1:0] rv,
                               input logic [DW-1:0] preg);
        logic [DW-1:0] hi_exp;
        int ale_sum, ps_sum;
        hi_exp = wide ? addr[AW-1:DW] : preg;
        fetch_addr = 16'h0F20; p2_reg = preg;
        data_req = 1'b1; data_wide = wide; data_write = wr;
        data_addr = addr; data_wdata = wd;
        run_cycle();
        chk("R5 one ack at cycle end", n_ack, 1);
        chk("R5 ack in last clock", int'(s_ack[MC-1]), 1);
        data_req = 1'b0; data_addr = 16'hFFFF; data_wdata = 8'h00;
        run_cycle();
        ale_sum = n_ale_rise; ps_sum = n_ps_fall;
        chk("R6 first access cycle psen pulses", n_ps_fall, 1);
        chk("R7 p0 data address low", int'(s_p0[6]), int'(addr[DW-1:0]));
        chk("R7 p0 driven at data ale", int'(s_oe[6]), 1);
        chk("R8 p2 at data ale", int'(s_p2[6]), int'(hi_exp));
        p0_in = rv;
        run_cycle();
        ale_sum += n_ale_rise; ps_sum += n_ps_fall;
        chk("R6 ale pulses over access", ale_sum, 3);
        chk("R6 psen pulses over access", ps_sum, 2);
        chk("R6 second cycle first ale slot", ale_pos0, 6);
        chk("R8 p2 during transfer", int'(s_p2[2]), int'(hi_exp));
        if (wr) begin
            chk("R9 one write strobe", n_wr_fall, 1);
            chk("R9 no read strobe", n_rd_fall, 0);
            chk("R9 p0 write data", int'(s_p0[4]), int'(wd));
            chk("R9 p0 driven for write", int'(s_oe[0] && s_oe[5]), 1);
        end else begin
            chk("R10 one read strobe", n_rd_fall, 1);
            chk("R10 no write strobe", n_wr_fall, 0);
            chk("R10 p0 released", int'(s_oe[0] || s_oe[5]), 0);
            chk("R10 valid pulse count", n_vld, 1);
            chk("R10 valid slot", int'(s_vld[6]), 1);
            chk("R10 read data", int'(rd_data), int'(rv));
        end
        p0_in = 8'h00;
    endtask

    task automatic test_back_to_back();
        fetch_addr = 16'h2200;
        data_req = 1'b1; data_wide = 1'b1; data_write = 1'b1;
        data_addr = 16'h4411; data_wdata = 8'hA1;
        run_cycle();
        chk("R12 first ack", n_ack, 1);
        data_addr = 16'h5522; data_wdata = 8'hB2;
        run_cycle();
        chk("R5 no ack in address cycle", n_ack, 0);
        chk("R12 first address", int'(s_p0[6]), 'h11);
        run_cycle();
        chk("R12 ack at end of transfer", int'(s_ack[MC-1]), 1);
        chk("R12 first write data", int'(s_p0[1]), 'hA1);
        data_req = 1'b0;
        run_cycle();
        chk("R12 second access address", int'(s_p0[6]), 'h22);
        chk("R12 second access psen", n_ps_fall, 1);
        chk("R12 second access high", int'(s_p2[6]), 'h55);
        run_cycle();
        chk("R12 second write data", int'(s_p0[2]), 'hB2);
        run_cycle();
        chk("R3 fetch cadence restored psen", n_ps_fall, 2);
        chk("R2 fetch cadence restored ale", n_ale_rise, 2);
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_fetch_ext();
        test_fetch_int();
        test_access(1'b1, 1'b1, 16'h12F0, 8'h6B, 8'h00, 8'h77);
        test_access(1'b0, 1'b0, 16'h7744, 8'h00, 8'hC3, 8'h9E);
        test_access(1'b1, 1'b0, 16'hBEEF, 8'h00, 8'h5A, 8'h01);
        test_back_to_back();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule